// File: doc/BRIEF.md
# Descriptor Ring Consumer with Wrap-Stamp Validation

This block is the reading side of a circular descriptor ring kept in a word-addressed memory. The ring holds `RING_WORDS / ENTRY_WORDS` fixed-size entries. The ring length in words does not have to be a power of two. A producer writes each entry and stamps it with a loop count. The consumer keeps a tail pointer and an expected loop count. It treats the entry at its tail as new only when the entry's stamp matches the count it expects. Because the stamp does the validation, the consumer never needs to read the producer's head pointer just to fetch the next entry.

Requests arrive on a valid/ready stream, and each accepted request produces one response on a second valid/ready stream. The block holds a single response register. A request is accepted only when that register is empty, or when it is being drained in the same cycle (`req_ready = !rsp_valid || rsp_ready`). While `rsp_valid` is high and `rsp_ready` is low, the response holds steady and no new request is accepted. The operations are:
- get-next: test the tail entry and advance past it.
- peek: test the tail entry without moving.
- count: return the number of valid entries, using either a freshly sampled or a cached producer head pointer.
- publish: copy the tail pointer onto the producer-visible output.

Top module: `dst_ring_consumer`

## Requirements
- R1: After reset the tail pointer, expected loop count, cached head pointer and published tail are all 0. `rsp_valid` is low, and `mem_addr` equals `ENTRY_WORDS-1`.
- R2: `req_op` uses these codes: 0 get-next, 1 peek, 2 count, 3 publish. A get-next whose stamp matches returns `rsp_hit=1` with `rsp_addr` set to the old tail. The tail then advances by `ENTRY_WORDS`, modulo `RING_WORDS`.
- R3: The stamp is `tag_rdata`, which is bits [31:28] of the memory word at `mem_addr = tail + ENTRY_WORDS - 1`. A get-next whose stamp differs from the expected loop count returns `rsp_hit=0` and leaves the tail and the loop count unchanged.
- R4: When a get-next moves the tail to 0, the expected loop count increments modulo 16.
- R5: A peek returns the same hit result and `rsp_addr` (the tail) as a get-next would, and changes neither the tail nor the loop count.
- R6: A count with `req_sync=1` uses `prod_hp` as the head pointer and stores it as the cached copy. It returns (hp-tp)/ENTRY_WORDS when hp >= tp, and otherwise (RING_WORDS-tp+hp)/ENTRY_WORDS.
- R7: A count with `req_sync=0` applies the same formula to the cached head pointer and ignores `prod_hp`.
- R8: `pub_tp` takes the current tail on a publish and changes on no other operation.
- R9: While `rsp_valid` is high and `rsp_ready` is low, `req_ready` is low. The response fields also stay stable, and a held request has no effect until it is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted this cycle when high with valid |
| req_op | input | 2 | Operation code |
| req_sync | input | 1 | Count uses the live head pointer when high |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Response consumed |
| rsp_hit | output | 1 | Tail entry valid (get-next and peek) |
| rsp_addr | output | PTR_W | Tail word offset at request time |
| rsp_count | output | CNT_W | Valid-entry count (count op, else 0) |
| mem_addr | output | PTR_W | Word address of the tail entry's last word |
| tag_rdata | input | 4 | Stamp field of the word at mem_addr |
| prod_hp | input | PTR_W | Producer head pointer, word offset |
| pub_tp | output | PTR_W | Published tail pointer |

## Verification
The bench walks the default 15-word, 5-entry ring for 18 laps. This carries the loop count through its 4-bit wrap, and it would catch a design that does not mask the count or that bumps it at the wrong position. At every tail position the bench first probes the entry with a stale stamp, then with a fresh one. A design that ignores the stamp would advance too early, and one whose peek moves the pointer would lose entries. At every tail position the count is also swept against every head position, both live and cached, to expose off-by-one wrap arithmetic or a cache that never refreshes. A stall test holds the response channel and checks that a pending get-next neither fires early nor gets lost.

// File: rtl/dr_pkg.sv
package dr_pkg;
  typedef enum logic [1:0] {
    OP_GET     = 2'd0,
    OP_PEEK    = 2'd1,
    OP_COUNT   = 2'd2,
    OP_PUBLISH = 2'd3
  } dr_op_e;
endpackage

// File: rtl/dr_step.sv
// Next tail pointer and loop count for a non-power-of-two ring.
module dr_step #(
  parameter int RING_WORDS  = 15,
  parameter int ENTRY_WORDS = 3,
  parameter int LC_W        = 4,
  localparam int PTR_W      = $clog2(RING_WORDS)
) (
  input  logic [PTR_W-1:0] tp,
  input  logic [LC_W-1:0]  lc,
  output logic [PTR_W-1:0] tp_next,
  output logic [LC_W-1:0]  lc_next,
  output logic [PTR_W-1:0] stamp_addr
);
  localparam logic [PTR_W:0] E_EXT = (PTR_W+1)'(ENTRY_WORDS);
  localparam logic [PTR_W:0] R_EXT = (PTR_W+1)'(RING_WORDS);

  logic [PTR_W:0] sum;
  logic [PTR_W:0] last_word;
  logic           wrap;

  always_comb begin
    sum       = {1'b0, tp} + E_EXT;
    wrap      = (sum >= R_EXT);
    tp_next   = wrap ? '0 : sum[PTR_W-1:0];
    lc_next   = wrap ? lc + 1'b1 : lc;
    last_word = sum - 1'b1;
    stamp_addr = last_word[PTR_W-1:0];
  end
endmodule

// File: rtl/dr_occupancy.sv
// Valid-entry count from head and tail word offsets.
module dr_occupancy #(
  parameter int RING_WORDS  = 15,
  parameter int ENTRY_WORDS = 3,
  localparam int PTR_W      = $clog2(RING_WORDS),
  localparam int CNT_W      = $clog2(RING_WORDS / ENTRY_WORDS + 1)
) (
  input  logic [PTR_W-1:0] hp,
  input  logic [PTR_W-1:0] tp,
  output logic [CNT_W-1:0] count
);
  localparam logic [PTR_W:0] E_EXT = (PTR_W+1)'(ENTRY_WORDS);
  localparam logic [PTR_W:0] R_EXT = (PTR_W+1)'(RING_WORDS);

  logic [PTR_W:0] span;
  logic [PTR_W:0] quot;

  always_comb begin
    if (hp >= tp) span = {1'b0, hp} - {1'b0, tp};
    else          span = R_EXT - {1'b0, tp} + {1'b0, hp};
    quot  = span / E_EXT;
    count = quot[CNT_W-1:0];
  end
endmodule

// File: rtl/dst_ring_consumer.sv
module dst_ring_consumer
  import dr_pkg::*;
#(
  parameter int RING_WORDS  = 15,
  parameter int ENTRY_WORDS = 3,
  parameter int LC_W        = 4,
  localparam int PTR_W      = $clog2(RING_WORDS),
  localparam int CNT_W      = $clog2(RING_WORDS / ENTRY_WORDS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [1:0]       req_op,
  input  logic             req_sync,
  output logic             rsp_valid,
  input  logic             rsp_ready,
  output logic             rsp_hit,
  output logic [PTR_W-1:0] rsp_addr,
  output logic [CNT_W-1:0] rsp_count,
  output logic [PTR_W-1:0] mem_addr,
  input  logic [LC_W-1:0]  tag_rdata,
  input  logic [PTR_W-1:0] prod_hp,
  output logic [PTR_W-1:0] pub_tp
);
  localparam logic [PTR_W-1:0] LAST_TP = PTR_W'(RING_WORDS - ENTRY_WORDS);
  localparam logic [PTR_W-1:0] E_PTR   = PTR_W'(ENTRY_WORDS);

  logic [PTR_W-1:0] tp_q, hp_cache_q, pub_q;
  logic [LC_W-1:0]  lc_q;
  logic [PTR_W-1:0] tp_next, hp_sel;
  logic [LC_W-1:0]  lc_next;
  logic [CNT_W-1:0] cnt;
  logic             accept, stamp_ok;
  dr_op_e           op;

  assign op        = dr_op_e'(req_op);
  assign req_ready = !rsp_valid || rsp_ready;
  assign accept    = req_valid && req_ready;
  assign stamp_ok  = (tag_rdata == lc_q);
  assign hp_sel    = req_sync ? prod_hp : hp_cache_q;
  assign pub_tp    = pub_q;

  dr_step #(.RING_WORDS(RING_WORDS), .ENTRY_WORDS(ENTRY_WORDS), .LC_W(LC_W)) u_step (
    .tp(tp_q), .lc(lc_q), .tp_next(tp_next), .lc_next(lc_next), .stamp_addr(mem_addr)
  );

  dr_occupancy #(.RING_WORDS(RING_WORDS), .ENTRY_WORDS(ENTRY_WORDS)) u_occ (
    .hp(hp_sel), .tp(tp_q), .count(cnt)
  );

  // Ring state
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tp_q       <= '0;
      lc_q       <= '0;
      hp_cache_q <= '0;
      pub_q      <= '0;
    end else if (accept) begin
      unique case (op)
        OP_GET: if (stamp_ok) begin
          tp_q <= tp_next;
          lc_q <= lc_next;
        end
        OP_COUNT:   if (req_sync) hp_cache_q <= prod_hp;
        OP_PUBLISH: pub_q <= tp_q;
        default: ;
      endcase
    end
  end

  // Response register
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_addr  <= '0;
      rsp_count <= '0;
    end else if (accept) begin
      rsp_valid <= 1'b1;
      rsp_hit   <= (op == OP_GET || op == OP_PEEK) && stamp_ok;
      rsp_addr  <= tp_q;
      rsp_count <= (op == OP_COUNT) ? cnt : '0;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  a_r1_tp_in_ring: assert property (@(posedge clk) disable iff (!rst_n)
    tp_q <= LAST_TP);

  a_r2_advance: assert property (@(posedge clk) disable iff (!rst_n)
    accept && op == OP_GET && stamp_ok && tp_q != LAST_TP
      |=> tp_q == PTR_W'($past(tp_q) + E_PTR));

  a_r3_miss_hold: assert property (@(posedge clk) disable iff (!rst_n)
    accept && op == OP_GET && !stamp_ok |=> $stable(tp_q) && $stable(lc_q));

  a_r4_lc_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    accept && op == OP_GET && stamp_ok && tp_q == LAST_TP
      |=> tp_q == '0 && lc_q == LC_W'($past(lc_q) + 1'b1));

  a_r5_peek_hold: assert property (@(posedge clk) disable iff (!rst_n)
    accept && op == OP_PEEK |=> $stable(tp_q) && $stable(lc_q));

  a_r8_pub_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(accept && op == OP_PUBLISH) |=> $stable(pub_tp));

  a_r9_rsp_hold: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_addr)
      && $stable(rsp_hit) && $stable(rsp_count));
endmodule

// File: tb/dst_ring_consumer_tb.sv
module dst_ring_consumer_tb;
  localparam int R = 15, E = 3, N = R / E;

  logic       clk = 1'b0, rst_n = 1'b0;
  logic       req_valid = 1'b0, req_sync = 1'b0, rsp_ready = 1'b1;
  logic [1:0] req_op = 2'd0;
  logic       req_ready, rsp_valid, rsp_hit;
  logic [3:0] rsp_addr, mem_addr, prod_hp = 4'd0, pub_tp;
  logic [2:0] rsp_count;
  logic [3:0] tag_rdata;
  logic [31:0] mem [0:R-1];

  int n_chk = 0, n_bad = 0;
  int etp = 0, elc = 0, cache_hp = 0, epub = 0;

  always #4 clk = ~clk;

  assign tag_rdata = mem[mem_addr][31:28];

  dst_ring_consumer u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_sync(req_sync), .rsp_valid(rsp_valid),
    .rsp_ready(rsp_ready), .rsp_hit(rsp_hit), .rsp_addr(rsp_addr),
    .rsp_count(rsp_count), .mem_addr(mem_addr), .tag_rdata(tag_rdata),
    .prod_hp(prod_hp), .pub_tp(pub_tp)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_op(input logic [1:0] op, input logic sync);
    @(negedge clk);
    req_valid = 1'b1; req_op = op; req_sync = sync;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  function automatic int occ(input int hp, input int tp);
    return (hp >= tp) ? (hp - tp) / E : (R - tp + hp) / E;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < R; i++) mem[i] = 32'hF000_0000 | i;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    // R1 reset state
    chk("R1 rsp_valid", rsp_valid, 0);
    chk("R1 req_ready", req_ready, 1);
    chk("R1 pub_tp", pub_tp, 0);
    chk("R1 mem_addr", mem_addr, E - 1);
    prod_hp = 4'd9;
    do_op(2'd2, 1'b0);
    chk("R1 cached hp zero", rsp_count, 0);

    for (int lap = 0; lap < 18; lap++) begin
      for (int e = 0; e < N; e++) begin
        // stale stamp: peek and get miss (R3, R5)
        do_op(2'd1, 1'b0);
        chk("R5 peek miss", rsp_hit, 0);
        chk("R5 peek addr", rsp_addr, etp);
        do_op(2'd0, 1'b0);
        chk("R3 get miss", rsp_hit, 0);
        chk("R8 pub unchanged", pub_tp, epub);
        do_op(2'd3, 1'b0);
        epub = etp;
        chk("R3 tail held", pub_tp, etp);
        // counts (R6, R7)
        for (int h = 0; h < N; h++) begin
          prod_hp = 4'(h * E);
          do_op(2'd2, 1'b1);
          cache_hp = h * E;
          chk("R6 sync count", rsp_count, occ(h * E, etp));
        end
        prod_hp = 4'(((e + 2) % N) * E);
        do_op(2'd2, 1'b0);
        chk("R7 cached count", rsp_count, occ(cache_hp, etp));
        // fresh stamp
        mem[etp + E - 1] = {4'(elc), 28'(lap * 16 + e)};
        do_op(2'd1, 1'b0);
        chk("R5 peek hit", rsp_hit, 1);
        chk("R5 peek addr", rsp_addr, etp);
        do_op(2'd1, 1'b0);
        chk("R5 peek repeat", rsp_hit, 1);
        do_op(2'd0, 1'b0);
        chk("R2 get hit", rsp_hit, 1);
        chk("R2 get addr", rsp_addr, etp);
        etp = (etp + E) % R;
        if (etp == 0) elc = (elc + 1) % 16;
        chk("R4 stamp addr", mem_addr, etp + E - 1);
        do_op(2'd3, 1'b0);
        epub = etp;
        chk("R2 tail advanced", pub_tp, etp);
      end
    end

    // R9 back-pressure: peek result held while a get waits
    mem[etp + E - 1] = {4'(elc), 28'd0};
    rsp_ready = 1'b0;
    do_op(2'd1, 1'b0);
    @(negedge clk);
    req_valid = 1'b1; req_op = 2'd0;
    repeat (3) @(negedge clk);
    chk("R9 req_ready low", req_ready, 0);
    chk("R9 rsp held valid", rsp_valid, 1);
    chk("R9 rsp held addr", rsp_addr, etp);
    chk("R9 no early advance", mem_addr, etp + E - 1);
    rsp_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    chk("R9 get after stall", rsp_hit, 1);
    etp = (etp + E) % R;
    do_op(2'd3, 1'b0);
    chk("R9 single advance", pub_tp, etp);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule